// File: doc/BRIEF.md
# Idle-Absorbing Elastic Packet Buffer

This block sits between a bursty producer and a consumer that takes at most one packet per cycle. In one cycle the producer hands over a bundle of one to four packets. A packet with the value zero is a filler: it carries no payload. The buffer throws fillers away as they arrive and never stores them. All other packets in the bundle go into a circular store in lane order within that same cycle.

On the consumer side, a request takes the oldest stored packet. If the store is empty, the buffer supplies a zero filler, so the consumer never stalls. A bundle can carry more payload packets than the store has room for. In that case the packets that fit are kept, the rest are lost, and a sticky overflow flag records the loss.

The block also keeps a high-water mark of its occupancy and two event counters, one for fillers dropped and one for fillers inserted. These let the store depth be sized against real traffic. The store depth, packet width, lane count and counter width are parameters. A parameter also selects whether the counters saturate or wrap.

Top module: `idle_absorb_buf`

## Requirements
- R1: A lane whose packet value is 0 is never written into the store, and it does not change the occupancy.
- R2: The dropped-filler counter `idle_dropped` rises by the number of zero-valued lanes inside each accepted bundle.
- R3: A request on an empty store drives `rd_data` to 0 in that cycle, adds 1 to `idle_inserted`, and leaves the occupancy at 0.
- R4: `wr_cnt` holds the bundle size minus one, and lane k sits at `wr_bundle[k*W +: W]`. Lanes at or above the bundle size are ignored, and payload packets are stored from the lowest lane upward.
- R5: Payload packets leave the store in the order they were stored, including across bundles (strict FIFO).
- R6: While the store is not empty, `rd_data` shows the oldest packet. A request removes exactly that one packet at the clock edge.
- R7: The free space for a bundle is the store depth minus the occupancy at the start of the cycle. Payload packets beyond that space are dropped, taking the highest lanes first. `overflow` then goes to 1 and stays at 1 until reset.
- R8: `high_water` equals the largest occupancy reached after any clock edge since reset.
- R9: A write and a request in the same cycle are both carried out. A packet written in that cycle is not visible on `rd_data` until the next cycle.
- R10: After reset, the occupancy, high-water mark, both counters and `overflow` are 0, and `rd_data` is 0.
- R11: With `SATURATE`=1, each counter stops at its all-ones value. With `SATURATE`=0, each counter wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Bundle present this cycle |
| wr_cnt | input | CW | Bundle size minus one |
| wr_bundle | input | LANES*W | Packets, lane 0 in the lowest bits |
| rd_req | input | 1 | Consumer takes one packet |
| rd_data | output | W | Oldest packet, or 0 when the store is empty |
| occupancy | output | OCC_W | Packets currently stored |
| high_water | output | OCC_W | Largest occupancy since reset |
| idle_dropped | output | CNT_W | Fillers discarded on entry |
| idle_inserted | output | CNT_W | Fillers supplied on empty requests |
| overflow | output | 1 | Sticky flag for payload lost to lack of space |

## Verification
The assertions check the following properties on every cycle:
- the occupancy never exceeds the depth;
- no zero-valued packet reaches a store write port;
- the high-water mark never falls and never lies below the occupancy;
- `overflow` never clears once set;
- each empty request advances the inserted-filler count.

Only the bench scenarios can show the rest:
- ordering across bundles;
- which lanes survive a partial overflow;
- lanes above the bundle size being ignored;
- the one-cycle delay before a freshly written packet appears on `rd_data`.

A sweep over every bundle size and every filler pattern covers these, with a reference queue giving the expected values.

// File: rtl/iab_pkg.sv
package iab_pkg;
   // Upper bound on lanes per bundle accepted by the elaboration checks.
   localparam int unsigned IAB_MAX_LANES = 8;

   function automatic int unsigned iab_sel_w(int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/iab_pack.sv
// Sorts one bundle: finds the filler lanes and gives each payload lane its
// slot offset behind the tail, limited by the free space.
module iab_pack #(
   parameter int unsigned W     = 8,
   parameter int unsigned LANES = 4,
   parameter int unsigned OCC_W = 5,
   parameter int unsigned CW    = 2,
   parameter int unsigned LC_W  = 3
) (
   input  logic                   wr_valid,
   input  logic [CW-1:0]          wr_cnt,
   input  logic [LANES*W-1:0]     wr_bundle,
   input  logic [OCC_W-1:0]       free,
   output logic [LANES-1:0]       lane_acc,
   output logic [LANES*OCC_W-1:0] lane_off,
   output logic [LC_W-1:0]        n_store,
   output logic [LC_W-1:0]        n_idle,
   output logic                   ovf_ev
);
   always_comb begin : c_pack
      int pos;
      int nid;
      pos      = 0;
      nid      = 0;
      ovf_ev   = 1'b0;
      lane_acc = '0;
      lane_off = '0;
      for (int k = 0; k < LANES; k++) begin
         if (wr_valid && (k <= int'(wr_cnt))) begin
            if (wr_bundle[k*W +: W] == '0) begin
               nid = nid + 1;
            end else if (pos < int'(free)) begin
               lane_acc[k]                = 1'b1;
               lane_off[k*OCC_W +: OCC_W] = OCC_W'(pos);
               pos                        = pos + 1;
            end else begin
               ovf_ev = 1'b1;
            end
         end
      end
      n_store = LC_W'(pos);
      n_idle  = LC_W'(nid);
   end
endmodule

// File: rtl/iab_ring.sv
// Circular store with several write ports, one read port and an occupancy count.
module iab_ring #(
   parameter int unsigned W     = 8,
   parameter int unsigned LANES = 4,
   parameter int unsigned DEPTH = 16,
   parameter int unsigned AW    = 4,
   parameter int unsigned OCC_W = 5,
   parameter int unsigned LC_W  = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [LANES-1:0]       lane_acc,
   input  logic [LANES*OCC_W-1:0] lane_off,
   input  logic [LANES*W-1:0]     wr_bundle,
   input  logic [LC_W-1:0]        n_store,
   input  logic                   pop,
   output logic [W-1:0]           head_data,
   output logic [OCC_W-1:0]       occ,
   output logic [OCC_W-1:0]       occ_nxt
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] head;
   logic [AW-1:0] tail;

   assign occ_nxt   = occ + OCC_W'(n_store) - OCC_W'(pop);
   assign head_data = mem[head];

   always_ff @(posedge clk) begin
      for (int k = 0; k < LANES; k++) begin
         if (lane_acc[k]) begin
            mem[tail + AW'(lane_off[k*OCC_W +: OCC_W])] <= wr_bundle[k*W +: W];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head <= '0;
         tail <= '0;
         occ  <= '0;
      end else begin
         head <= head + AW'(pop);
         tail <= tail + AW'(n_store);
         occ  <= occ_nxt;
      end
   end

   p_occ_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= OCC_W'(DEPTH));

   for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
      p_no_filler_stored_r1: assert property (@(posedge clk) disable iff (!rst_n)
         lane_acc[k] |-> (wr_bundle[k*W +: W] != '0));
   end
endmodule

// File: rtl/iab_stats.sv
// Filler counters, high-water mark and sticky overflow flag.
module iab_stats #(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned OCC_W    = 5,
   parameter int unsigned LC_W     = 3,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LC_W-1:0]  n_idle,
   input  logic             ins_ev,
   input  logic             ovf_ev,
   input  logic [OCC_W-1:0] occ_nxt,
   output logic [CNT_W-1:0] drop_cnt,
   output logic [CNT_W-1:0] ins_cnt,
   output logic [OCC_W-1:0] hwm,
   output logic             ovf
);
   logic [CNT_W:0]   drop_sum;
   logic [CNT_W:0]   ins_sum;
   logic [CNT_W-1:0] drop_nxt;
   logic [CNT_W-1:0] ins_nxt;

   assign drop_sum = {1'b0, drop_cnt} + (CNT_W+1)'(n_idle);
   assign ins_sum  = {1'b0, ins_cnt} + (CNT_W+1)'(ins_ev);

   if (SATURATE) begin : g_sat
      assign drop_nxt = drop_sum[CNT_W] ? '1 : drop_sum[CNT_W-1:0];
      assign ins_nxt  = ins_sum[CNT_W]  ? '1 : ins_sum[CNT_W-1:0];
   end else begin : g_wrap
      assign drop_nxt = drop_sum[CNT_W-1:0];
      assign ins_nxt  = ins_sum[CNT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         drop_cnt <= '0;
         ins_cnt  <= '0;
         hwm      <= '0;
         ovf      <= 1'b0;
      end else begin
         drop_cnt <= drop_nxt;
         ins_cnt  <= ins_nxt;
         hwm      <= (occ_nxt > hwm) ? occ_nxt : hwm;
         ovf      <= ovf | ovf_ev;
      end
   end

   p_hwm_mono_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hwm >= $past(hwm));

   p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ovf) |-> ovf);
endmodule

// File: rtl/idle_absorb_buf.sv
module idle_absorb_buf
   import iab_pkg::*;
#(
   parameter int unsigned W        = 8,
   parameter int unsigned LANES    = 4,
   parameter int unsigned DEPTH    = 16,
   parameter int unsigned CNT_W    = 16,
   parameter bit          SATURATE = 1'b1,
   localparam int unsigned CW      = iab_sel_w(LANES),
   localparam int unsigned AW      = iab_sel_w(DEPTH),
   localparam int unsigned OCC_W   = AW + 1,
   localparam int unsigned LC_W    = $clog2(LANES + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_valid,
   input  logic [CW-1:0]      wr_cnt,
   input  logic [LANES*W-1:0] wr_bundle,
   input  logic               rd_req,
   output logic [W-1:0]       rd_data,
   output logic [OCC_W-1:0]   occupancy,
   output logic [OCC_W-1:0]   high_water,
   output logic [CNT_W-1:0]   idle_dropped,
   output logic [CNT_W-1:0]   idle_inserted,
   output logic               overflow
);
   if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end
   if ((LANES < 1) || (LANES > IAB_MAX_LANES) || (LANES > DEPTH)) begin : g_bad_lanes
      $error("LANES out of range");
   end
   if ((W < 1) || (CNT_W < LC_W)) begin : g_bad_width
      $error("W or CNT_W too small");
   end

   logic [LANES-1:0]       lane_acc;
   logic [LANES*OCC_W-1:0] lane_off;
   logic [LC_W-1:0]        n_store;
   logic [LC_W-1:0]        n_idle;
   logic                   ovf_ev;
   logic [OCC_W-1:0]       occ;
   logic [OCC_W-1:0]       occ_nxt;
   logic [OCC_W-1:0]       free;
   logic [W-1:0]           head_data;
   logic                   empty;
   logic                   pop;
   logic                   ins_ev;

   assign empty   = (occ == '0);
   assign free    = OCC_W'(DEPTH) - occ;
   assign pop     = rd_req && !empty;
   assign ins_ev  = rd_req && empty;
   assign rd_data = empty ? '0 : head_data;
   assign occupancy = occ;

   iab_pack #(.W(W), .LANES(LANES), .OCC_W(OCC_W), .CW(CW), .LC_W(LC_W)) i_pack (
      .wr_valid (wr_valid),
      .wr_cnt   (wr_cnt),
      .wr_bundle(wr_bundle),
      .free     (free),
      .lane_acc (lane_acc),
      .lane_off (lane_off),
      .n_store  (n_store),
      .n_idle   (n_idle),
      .ovf_ev   (ovf_ev)
   );

   iab_ring #(.W(W), .LANES(LANES), .DEPTH(DEPTH), .AW(AW), .OCC_W(OCC_W), .LC_W(LC_W)) i_ring (
      .clk      (clk),
      .rst_n    (rst_n),
      .lane_acc (lane_acc),
      .lane_off (lane_off),
      .wr_bundle(wr_bundle),
      .n_store  (n_store),
      .pop      (pop),
      .head_data(head_data),
      .occ      (occ),
      .occ_nxt  (occ_nxt)
   );

   iab_stats #(.CNT_W(CNT_W), .OCC_W(OCC_W), .LC_W(LC_W), .SATURATE(SATURATE)) i_stats (
      .clk     (clk),
      .rst_n   (rst_n),
      .n_idle  (n_idle),
      .ins_ev  (ins_ev),
      .ovf_ev  (ovf_ev),
      .occ_nxt (occ_nxt),
      .drop_cnt(idle_dropped),
      .ins_cnt (idle_inserted),
      .hwm     (high_water),
      .ovf     (overflow)
   );

   p_hwm_cover_r8: assert property (@(posedge clk) disable iff (!rst_n)
      high_water >= occupancy);

   p_ins_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && (occupancy == '0) && (idle_inserted != '1))
      |=> (idle_inserted == CNT_W'($past(idle_inserted) + 1'b1)));
endmodule

// File: tb/test_idle_absorb_buf.sv
module test_idle_absorb_buf;
   localparam int W = 8, LANES = 4, DEP = 8, CNT_W = 6, CMAX = 63;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_valid = 1'b0;
   logic [1:0]  wr_cnt = '0;
   logic [31:0] wr_bundle = '0;
   logic        rd_req = 1'b0;
   logic [7:0]  rd_data;
   logic [3:0]  occupancy, high_water;
   logic [5:0]  idle_dropped, idle_inserted;
   logic        overflow;

   int checks = 0, fails = 0;
   int q[$];
   int m_drop = 0, m_ins = 0, m_hwm = 0;
   bit m_ovf = 0;
   int seq = 1;

   always #5 clk = ~clk;

   idle_absorb_buf #(.W(W), .LANES(LANES), .DEPTH(DEP), .CNT_W(CNT_W), .SATURATE(1'b1)) i_idle_absorb_buf (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_cnt(wr_cnt),
      .wr_bundle(wr_bundle), .rd_req(rd_req), .rd_data(rd_data),
      .occupancy(occupancy), .high_water(high_water),
      .idle_dropped(idle_dropped), .idle_inserted(idle_inserted),
      .overflow(overflow));

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int sat(int v);
      return (v > CMAX) ? CMAX : v;
   endfunction

   function automatic int next_val();
      int v = seq;
      seq = (seq % 255) + 1;
      return v;
   endfunction

   task automatic step(string tag, bit v, int n, logic [31:0] b, bit rd);
      int pre, free;
      @(negedge clk);
      wr_valid = v; wr_cnt = 2'(n - 1); wr_bundle = b; rd_req = rd;
      #1;
      if (rd) check({tag, " rd_data (R6/R3/R9)"}, int'(rd_data), (q.size() > 0) ? q[0] : 0);
      @(posedge clk);
      pre = q.size();
      free = DEP - pre;
      if (rd) begin
         if (pre > 0) void'(q.pop_front());
         else m_ins = sat(m_ins + 1);
      end
      if (v) begin
         for (int k = 0; k < n; k++) begin
            int val = int'(b[k*8 +: 8]);
            if (val == 0) m_drop = sat(m_drop + 1);
            else if (free > 0) begin q.push_back(val); free--; end
            else m_ovf = 1;
         end
      end
      if (q.size() > m_hwm) m_hwm = q.size();
      #1;
      check({tag, " occupancy (R1/R5)"}, int'(occupancy), q.size());
      check({tag, " idle_dropped (R2)"}, int'(idle_dropped), m_drop);
      check({tag, " idle_inserted (R3)"}, int'(idle_inserted), m_ins);
      check({tag, " overflow (R7)"}, int'(overflow), int'(m_ovf));
      check({tag, " high_water (R8)"}, int'(high_water), m_hwm);
      @(negedge clk);
      wr_valid = 0; rd_req = 0;
   endtask

   task automatic drain(string tag);
      while (q.size() > 0) step(tag, 0, 1, '0, 1);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] b;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R10: reset state
      check("R10 occupancy", int'(occupancy), 0);
      check("R10 high_water", int'(high_water), 0);
      check("R10 idle_dropped", int'(idle_dropped), 0);
      check("R10 idle_inserted", int'(idle_inserted), 0);
      check("R10 overflow", int'(overflow), 0);
      check("R10 rd_data", int'(rd_data), 0);

      // R3: requests on an empty store
      for (int i = 0; i < 3; i++) step("R3 empty", 0, 1, '0, 1);

      // R4/R1/R2/R5: every bundle size against every filler pattern; lanes above size carry junk
      for (int n = 1; n <= 4; n++) begin
         for (int m = 0; m < 16; m++) begin
            for (int k = 0; k < 4; k++)
               b[k*8 +: 8] = (k >= n) ? 8'hA5 : (m[k] ? 8'(next_val()) : 8'h00);
            step("R4 sweep", 1, n, b, 0);
            drain("R5 drain");
         end
      end

      // R9: write and request together on an empty store
      step("R9 same-cycle", 1, 1, 32'h0000_0042, 1);
      step("R9 next-cycle", 0, 1, '0, 1);
      // R9: write and request together on a non-empty store
      step("R9 prime", 1, 2, 32'h0000_0B0A, 0);
      step("R9 both", 1, 1, 32'h0000_000C, 1);
      drain("R5 drain");

      // R7: fill, then overflow with a read in the same cycle
      step("R7 fill", 1, 4, 32'h04030201, 0);
      step("R7 fill", 1, 4, 32'h08070605, 0);
      step("R7 full", 1, 4, 32'h0C0B0A09, 1);
      step("R7 partial", 1, 4, 32'h0F000E0D, 0);
      drain("R7 drain");
      // R8: high-water mark survives the drain
      check("R8 hold", int'(high_water), DEP);

      // R6: mixed traffic
      for (int i = 0; i < 400; i++) begin
         int n = int'($urandom_range(1, 4));
         for (int k = 0; k < 4; k++)
            b[k*8 +: 8] = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'(next_val());
         step("R6 mixed", $urandom_range(0, 1) == 1, n, b, $urandom_range(0, 2) != 0);
      end
      drain("R6 drain");

      // R11: counters saturate
      for (int i = 0; i < 20; i++) step("R11 drops", 1, 4, '0, 0);
      for (int i = 0; i < 70; i++) step("R11 inserts", 0, 1, '0, 1);
      check("R11 drop sat", int'(idle_dropped), CMAX);
      check("R11 ins sat", int'(idle_inserted), CMAX);

      summary();
      $finish;
   end
endmodule